// File: doc/BRIEF.md
# I2C Event Flag and Status Unit

This block is the service-request stage of a byte-oriented I2C engine. The bit-level engine reports each bus event with a one-cycle strobe on one line of an event vector. The unit then raises a pending flag, and one clock later it publishes an 8-bit code that names the event. While the flag is pending the unit asks the pad logic to keep SCL low. This stretches the bus until software has read the code and set up the next step. When local and global interrupt enables are both on, the pending flag also raises an interrupt request. With the local enable off, software polls the flag instead.

Software acknowledges an event by writing a one into the flag position of the control register. That clears the flag, returns the status output to the idle code and lets SCL go. There is also a low-power abort. If some other wake-up source fires while an address match is pending in a low-power state, the unit drops any pending event and returns to idle.

Top module: `i2c_evt_status_unit`

## Requirements
- R1: A one-cycle pulse on any line of `evt_strb` sets `flag` at the next rising clock edge. The lines are: 0 start or repeated start sent, 1 slave address with direction bit sent, 2 address byte sent, 3 arbitration lost, 4 own address or general call matched, 5 data byte received, 6 stop or repeated start seen while addressed as slave, 7 bus error from a misplaced start or stop.
- R2: The event code for line k (0 to 6) is 8*(k+1), and for line 7 it is 0x00, so the low three bits are always zero. `status` takes this code at the clock edge one cycle after `flag` became set.
- R3: Whenever `flag` is 0, `status` reads 0xF8.
- R4: `scl_hold` is 1 exactly while `flag` is 1. Once set, it stays set until a software clear or an abort.
- R5: `irq` is 1 only when `flag`, `ie` and `gie` are all 1. `flag` sets the same way whatever the enables are.
- R6: When `lp_match_pend` and `foreign_wake` are both 1 at an edge, the flag clears and `status` returns to 0xF8, even if an event strobe arrives on that same cycle.
- R7: A cycle with `reg_wr_en`=1 and `reg_wr_flag`=1 clears the flag at that edge. A write with `reg_wr_flag`=0, or a cycle with `reg_wr_en`=0, leaves `flag` and `status` unchanged.
- R8: If an event strobe and a clearing write arrive on the same cycle, the event wins. The flag stays set, `status` keeps its old code for one cycle, and then it shows the new code.
- R9: If several strobe lines pulse together, the highest-numbered line selects the code.
- R10: Synchronous reset clears `flag`, `scl_hold` and `irq`, and sets `status` to 0xF8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_strb | input | 8 | One-cycle event strobes from the bus engine |
| ie | input | 1 | Local interrupt enable |
| gie | input | 1 | Global interrupt enable |
| lp_match_pend | input | 1 | An address match is pending in low-power state |
| foreign_wake | input | 1 | A wake-up source other than the address match fired |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_flag | input | 1 | Value written into the flag bit position |
| flag | output | 1 | Pending-service flag |
| status | output | 8 | Event code, or 0xF8 when nothing is pending |
| scl_hold | output | 1 | Request to hold SCL low |
| irq | output | 1 | Interrupt request |

## Verification
The bench pulses every event line on its own under all four enable combinations. Each run checks the one-cycle gap between flag and code, the code value derived from the line index, and the interrupt gating. Pairs of simultaneous strobes are swept to separate the priority order from a plain OR of codes. Further sequences place a clearing write on the same cycle as a new event, clear during the code-load cycle, write a zero, and drive each abort input alone and then both together with a strobe. These show whether clears, no-op writes and aborts are ordered correctly against new events.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  localparam int unsigned CODE_W    = 8;
  localparam logic [CODE_W-1:0] IDLE_CODE = 8'hF8;

  typedef enum int unsigned {
    EV_START_SENT = 0,
    EV_ADDR_RW    = 1,
    EV_ADDR_BYTE  = 2,
    EV_ARB_LOST   = 3,
    EV_OWN_MATCH  = 4,
    EV_DATA_RX    = 5,
    EV_SLV_STOP   = 6,
    EV_BUS_ERR    = 7
  } evt_idx_e;

  // Code of an event line: last line (bus error) is zero, others step by 8.
  function automatic logic [CODE_W-1:0] evt_code(int unsigned idx, int unsigned n);
    if (idx == n - 1) return '0;
    return CODE_W'((idx + 1) << 3);
  endfunction
endpackage

// File: rtl/i2c_evt_prio.sv
module i2c_evt_prio
  import i2c_evt_pkg::*;
#(
  parameter int unsigned NUM_EVT = 8
) (
  input  logic [NUM_EVT-1:0] strb,
  output logic               any_evt,
  output logic [CODE_W-1:0]  code
);
  // R9: scan upward so the highest active line is the one kept
  always_comb begin
    any_evt = |strb;
    code    = IDLE_CODE;
    for (int unsigned i = 0; i < NUM_EVT; i++) begin
      if (strb[i]) code = evt_code(i, NUM_EVT);
    end
  end
endmodule

// File: rtl/i2c_evt_flag.sv
module i2c_evt_flag (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic clr,
  input  logic abort,
  output logic flag_nxt,
  output logic flag_q
);
  // R6 abort beats everything, R8 event beats clear
  always_comb begin
    if (abort)      flag_nxt = 1'b0;
    else if (fire)  flag_nxt = 1'b1;
    else if (clr)   flag_nxt = 1'b0;
    else            flag_nxt = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= flag_nxt;
  end
endmodule

// File: rtl/i2c_evt_status.sv
module i2c_evt_status
  import i2c_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              abort,
  input  logic              flag_nxt,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] status_q
);
  logic              load_q;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q   <= 1'b0;
      code_q   <= IDLE_CODE;
      status_q <= IDLE_CODE;
    end else begin
      load_q <= fire && !abort;
      if (fire) code_q <= code_in;
      if (!flag_nxt)   status_q <= IDLE_CODE;
      else if (load_q) status_q <= code_q;
    end
  end
endmodule

// File: rtl/i2c_evt_status_unit.sv
module i2c_evt_status_unit
  import i2c_evt_pkg::*;
#(
  parameter int unsigned NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_strb,
  input  logic               ie,
  input  logic               gie,
  input  logic               lp_match_pend,
  input  logic               foreign_wake,
  input  logic               reg_wr_en,
  input  logic               reg_wr_flag,
  output logic               flag,
  output logic [CODE_W-1:0]  status,
  output logic               scl_hold,
  output logic               irq
);
  // named internal events, visible to the bound checker
  logic              fire_w;
  logic              clr_w;
  logic              abort_w;
  logic              flag_nxt_w;
  logic [CODE_W-1:0] evt_code_w;

  assign clr_w   = reg_wr_en & reg_wr_flag;
  assign abort_w = lp_match_pend & foreign_wake;

  i2c_evt_prio #(.NUM_EVT(NUM_EVT)) u_prio (
    .strb    (evt_strb),
    .any_evt (fire_w),
    .code    (evt_code_w)
  );

  i2c_evt_flag u_flag (
    .clk      (clk),
    .rst      (rst),
    .fire     (fire_w),
    .clr      (clr_w),
    .abort    (abort_w),
    .flag_nxt (flag_nxt_w),
    .flag_q   (flag)
  );

  i2c_evt_status u_stat (
    .clk      (clk),
    .rst      (rst),
    .fire     (fire_w),
    .abort    (abort_w),
    .flag_nxt (flag_nxt_w),
    .code_in  (evt_code_w),
    .status_q (status)
  );

  assign scl_hold = flag;
  assign irq      = flag & ie & gie;
endmodule

// File: rtl/i2c_evt_status_chk.sv
module i2c_evt_status_chk
  import i2c_evt_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              fire_w,
  input logic              clr_w,
  input logic              abort_w,
  input logic              flag_nxt_w,
  input logic [CODE_W-1:0] evt_code_w,
  input logic              flag,
  input logic [CODE_W-1:0] status,
  input logic              scl_hold,
  input logic              irq,
  input logic              ie,
  input logic              gie
);
  AST_SET_ON_EVENT: assert property (@(posedge clk) disable iff (rst)
    (fire_w && !abort_w) |=> flag); // R1

  AST_CODE_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ((fire_w && !abort_w) ##1 flag_nxt_w) |=> (status == $past(evt_code_w, 2))); // R2

  AST_CODE_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    flag |-> (status[2:0] == 3'b000)); // R2

  AST_IDLE_WHEN_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !flag |-> (status == IDLE_CODE)); // R3

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
    (scl_hold && !clr_w && !abort_w) |=> scl_hold); // R4

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq |-> (scl_hold && ie && gie)); // R5

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
    abort_w |=> (!flag && status == IDLE_CODE)); // R6

  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (fire_w && clr_w && !abort_w) |=> scl_hold); // R8
endmodule

bind i2c_evt_status_unit i2c_evt_status_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .fire_w     (fire_w),
  .clr_w      (clr_w),
  .abort_w    (abort_w),
  .flag_nxt_w (flag_nxt_w),
  .evt_code_w (evt_code_w),
  .flag       (flag),
  .status     (status),
  .scl_hold   (scl_hold),
  .irq        (irq),
  .ie         (ie),
  .gie        (gie)
);

// File: tb/sim_i2c_evt_status_unit.sv
`timescale 1ns/100ps
module sim_i2c_evt_status_unit;
  localparam int N = 8;
  localparam logic [7:0] IDLE = 8'hF8;

  logic clk = 1'b0;
  logic rst;
  logic [N-1:0] evt_strb;
  logic ie, gie, lp_match_pend, foreign_wake, reg_wr_en, reg_wr_flag;
  logic flag, scl_hold, irq;
  logic [7:0] status;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_evt_status_unit u0 (
    .clk(clk), .rst(rst), .evt_strb(evt_strb), .ie(ie), .gie(gie),
    .lp_match_pend(lp_match_pend), .foreign_wake(foreign_wake),
    .reg_wr_en(reg_wr_en), .reg_wr_flag(reg_wr_flag),
    .flag(flag), .status(status), .scl_hold(scl_hold), .irq(irq)
  );

  // bench's own view of the code table: line 7 is zero, others 8 apart
  function automatic logic [7:0] want_code(int k);
    return (k == 7) ? 8'h00 : 8'(8 * k + 8);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic ack();
    reg_wr_en = 1'b1; reg_wr_flag = 1'b1;
    tick();
    reg_wr_en = 1'b0; reg_wr_flag = 1'b0;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; evt_strb = '0; ie = 0; gie = 0;
    lp_match_pend = 0; foreign_wake = 0; reg_wr_en = 0; reg_wr_flag = 0;
    tick(); tick();
    // R10 reset state
    check("R10 flag", flag, 0);
    check("R10 status", status, IDLE);
    check("R10 scl_hold", scl_hold, 0);
    check("R10 irq", irq, 0);
    rst = 1'b0;
    tick();

    // R1 R2 R3 R4 R5 sweep: every line under every enable pair
    for (int k = 0; k < N; k++) begin
      for (int e = 0; e < 4; e++) begin
        ie = e[0]; gie = e[1];
        evt_strb = N'(1) << k;
        tick();
        evt_strb = '0;
        check("R1 flag set", flag, 1);
        check("R2 code not yet loaded", status, IDLE);
        check("R4 scl held", scl_hold, 1);
        check("R5 irq gating", irq, e[0] & e[1]);
        tick();
        check("R2 code loaded", status, want_code(k));
        check("R4 still held", scl_hold, 1);
        ack();
        check("R7 cleared", flag, 0);
        check("R3 idle after clear", status, IDLE);
        check("R4 released", scl_hold, 0);
        check("R5 irq off", irq, 0);
      end
    end
    ie = 1; gie = 1;

    // R7 writes that must not clear
    evt_strb = 8'h20; tick(); evt_strb = '0; tick();
    reg_wr_en = 1; reg_wr_flag = 0; tick();
    check("R7 write zero keeps flag", flag, 1);
    check("R7 write zero keeps code", status, want_code(5));
    reg_wr_en = 0; reg_wr_flag = 1; tick();
    check("R7 no strobe keeps flag", flag, 1);
    check("R7 no strobe keeps code", status, want_code(5));
    reg_wr_flag = 0;

    // R8 event and clear together
    evt_strb = 8'h02; reg_wr_en = 1; reg_wr_flag = 1; tick();
    evt_strb = '0; reg_wr_en = 0; reg_wr_flag = 0;
    check("R8 flag kept", flag, 1);
    check("R8 old code one cycle", status, want_code(5));
    tick();
    check("R8 new code", status, want_code(1));
    ack();

    // R3 clear during the load cycle
    evt_strb = 8'h08; tick(); evt_strb = '0;
    ack();
    check("R3 clear in load cycle flag", flag, 0);
    check("R3 clear in load cycle status", status, IDLE);
    tick();
    check("R3 stays idle", status, IDLE);

    // R9 pairwise priority sweep
    for (int a = 0; a < N; a++) begin
      for (int b = a + 1; b < N; b++) begin
        evt_strb = (N'(1) << a) | (N'(1) << b);
        tick(); evt_strb = '0; tick();
        check("R9 highest line wins", status, want_code(b));
        ack();
      end
    end

    // R6 abort: single inputs have no effect, both together abort
    evt_strb = 8'h10; tick(); evt_strb = '0; tick();
    lp_match_pend = 1; tick();
    check("R6 pend alone no effect", flag, 1);
    lp_match_pend = 0; foreign_wake = 1; tick();
    check("R6 wake alone no effect", status, want_code(4));
    lp_match_pend = 1; evt_strb = 8'h01; tick();
    lp_match_pend = 0; foreign_wake = 0; evt_strb = '0;
    check("R6 abort clears flag", flag, 0);
    check("R6 abort idles status", status, IDLE);
    check("R6 abort drops irq", irq, 0);
    tick();
    check("R6 nothing reloads", status, IDLE);

    // R10 reset while pending
    evt_strb = 8'h80; tick(); evt_strb = '0; tick();
    check("R2 bus error code", status, 8'h00);
    rst = 1; tick(); rst = 0;
    check("R10 reset clears flag", flag, 0);
    check("R10 reset idle", status, IDLE);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule